// File: doc/BRIEF.md
# Adaptive Four-Element Complex Beamformer

This block takes one complex baseband sample from each of four antennas and produces a single combined sample. Each antenna has a complex weight. The output is the sum of each sample times the complex conjugate of its weight. Every valid sample also adapts the weights by a stochastic-gradient step. The step is the antenna sample times the conjugate of an error term, scaled by a power-of-two step size.

The error term comes from one of two sources, chosen per sample by a mode input. In reference mode, a known training sample is supplied and the error is that reference minus the output. In blind mode, no reference and no synchronisation are needed. The error then drives the output towards unit magnitude, which suits constant-envelope signals.

With four elements the adapted pattern can place up to three nulls on interferers. A small step size gives a quieter steady state but adapts more slowly.

All data and weights are signed 16-bit values with 14 fraction bits, so 16384 represents 1.0. Antenna k occupies bits [16k+15:16k] of the packed input vectors.

Top module: `cmab_beamformer`

## Requirements
- R1: While reset is applied and straight after it, `out_valid` is 0 and `y_re`/`y_im` are 0. Weight 0 is 16384+j0 and the other weights are 0, so the first valid output equals antenna 0's input.
- R2: For a sample accepted with `in_valid`=1, the output is computed as follows, and appears on `y_re`/`y_im` one clock later:
  - `y_re` = Σ(wr·xr + wi·xi) and `y_im` = Σ(wr·xi − wi·xr), each summed over the four antennas.
  - Each full-precision sum is rounded by adding 2^13 and then arithmetic-shifting right by 14.
- R3: `out_valid` equals `in_valid` delayed by one clock. In a cycle that follows `in_valid`=0, `y_re`/`y_im` keep their previous values.
- R4: When `in_valid` is 0, the weights do not change, whatever the values on the data, reference, mode and step inputs.
- R5: With `lms_mode`=1, the error is the reference minus the current output (e = ref − y), saturated to 16 bits per component.
- R6: With `lms_mode`=0, the error is computed in two steps:
  - m = round14(y_re² + y_im²).
  - e = saturate(round14((16384 − m)·y)), applied to each component of y.
- R7: Each valid sample updates the weights with s = `mu_shift` (0 to 15):
  - w_k += round_{14+s}(x_k·conj(e)).
  - The real part of x_k·conj(e) is xr·er + xi·ei; the imaginary part is xi·er − xr·ei.
  - round_n adds 2^(n−1) and then arithmetic-shifts right by n.
- R8: Updated weights saturate to the range −32768 to 32767 per component and never wrap.
- R9: The output saturates to the range −32768 to 32767 per component when the rounded sum leaves that range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Qualifies the antenna samples, reference, mode and step |
| x_re | input | 64 | Real parts of the four antenna samples, antenna k at [16k+15:16k] |
| x_im | input | 64 | Imaginary parts of the four antenna samples |
| ref_re | input | 16 | Real part of the training reference |
| ref_im | input | 16 | Imaginary part of the training reference |
| lms_mode | input | 1 | 1 selects the reference error, 0 selects the blind modulus error |
| mu_shift | input | 4 | Step size as a right shift of 0 to 15 bits |
| out_valid | output | 1 | Output sample valid |
| y_re | output | 16 | Real part of the combined output |
| y_im | output | 16 | Imaginary part of the combined output |

## Verification
The weights cannot be seen at the ports. Their saturation and their freezing between samples can only be inferred from later outputs. To drive the weights into their limit, the bench uses full-scale antenna inputs with a full-scale reference of opposite sign and zero shift. One update then overshoots the weight range, and the next output exposes both the weight clamp and the output clamp. To test freezing, the bench disturbs every input while the sample is not valid. It then sends a valid sample whose expected value assumes untouched weights.

// File: rtl/cmab_pkg.sv
package cmab_pkg;

   typedef enum logic {
      ERR_BLIND = 1'b0,
      ERR_REF   = 1'b1
   } err_sel_e;

   // round half up, then arithmetic shift right; sh >= 1
   function automatic logic signed [63:0] round_shift(input logic signed [63:0] v, input int sh);
      return (v + (64'sd1 <<< (sh - 1))) >>> sh;
   endfunction

endpackage

// File: rtl/cmab_combiner.sv
module cmab_combiner import cmab_pkg::*; #(
   parameter int NUM_ANT = 4,
   parameter int DW      = 16,
   parameter int FRAC    = 14
)(
   input  logic [NUM_ANT*DW-1:0] x_re,
   input  logic [NUM_ANT*DW-1:0] x_im,
   input  logic [NUM_ANT*DW-1:0] w_re,
   input  logic [NUM_ANT*DW-1:0] w_im,
   output logic signed [DW-1:0]  y_re,
   output logic signed [DW-1:0]  y_im
);
   function automatic logic signed [DW-1:0] sat_d(input logic signed [63:0] v);
      logic signed [63:0] hi = (64'sd1 <<< (DW - 1)) - 64'sd1;
      logic signed [63:0] lo = -(64'sd1 <<< (DW - 1));
      if (v > hi) return hi[DW-1:0];
      if (v < lo) return lo[DW-1:0];
      return v[DW-1:0];
   endfunction

   logic signed [63:0] prod_re [NUM_ANT];
   logic signed [63:0] prod_im [NUM_ANT];
   logic signed [63:0] sum_re, sum_im;

   for (genvar k = 0; k < NUM_ANT; k++) begin : g_tap
      logic signed [DW-1:0] xr, xi, wr, wi;
      assign xr = x_re[k*DW +: DW];
      assign xi = x_im[k*DW +: DW];
      assign wr = w_re[k*DW +: DW];
      assign wi = w_im[k*DW +: DW];
      // conj(w) * x
      assign prod_re[k] = 64'(wr) * 64'(xr) + 64'(wi) * 64'(xi);
      assign prod_im[k] = 64'(wr) * 64'(xi) - 64'(wi) * 64'(xr);
   end

   always_comb begin
      sum_re = '0;
      sum_im = '0;
      for (int k = 0; k < NUM_ANT; k++) begin
         sum_re = sum_re + prod_re[k];
         sum_im = sum_im + prod_im[k];
      end
   end

   assign y_re = sat_d(round_shift(sum_re, FRAC));
   assign y_im = sat_d(round_shift(sum_im, FRAC));
endmodule

// File: rtl/cmab_error.sv
module cmab_error import cmab_pkg::*; #(
   parameter int DW   = 16,
   parameter int FRAC = 14
)(
   input  err_sel_e             sel,
   input  logic signed [DW-1:0] y_re,
   input  logic signed [DW-1:0] y_im,
   input  logic signed [DW-1:0] ref_re,
   input  logic signed [DW-1:0] ref_im,
   output logic signed [DW-1:0] e_re,
   output logic signed [DW-1:0] e_im
);
   function automatic logic signed [DW-1:0] sat_d(input logic signed [63:0] v);
      logic signed [63:0] hi = (64'sd1 <<< (DW - 1)) - 64'sd1;
      logic signed [63:0] lo = -(64'sd1 <<< (DW - 1));
      if (v > hi) return hi[DW-1:0];
      if (v < lo) return lo[DW-1:0];
      return v[DW-1:0];
   endfunction

   logic signed [63:0] mag, gain;
   logic signed [DW-1:0] cm_re, cm_im, ref_err_re, ref_err_im;

   assign mag  = round_shift(64'(y_re) * 64'(y_re) + 64'(y_im) * 64'(y_im), FRAC);
   assign gain = (64'sd1 <<< FRAC) - mag;

   assign cm_re = sat_d(round_shift(gain * 64'(y_re), FRAC));
   assign cm_im = sat_d(round_shift(gain * 64'(y_im), FRAC));

   assign ref_err_re = sat_d(64'(ref_re) - 64'(y_re));
   assign ref_err_im = sat_d(64'(ref_im) - 64'(y_im));

   assign e_re = (sel == ERR_REF) ? ref_err_re : cm_re;
   assign e_im = (sel == ERR_REF) ? ref_err_im : cm_im;
endmodule

// File: rtl/cmab_weight_lane.sv
module cmab_weight_lane import cmab_pkg::*; #(
   parameter int DW     = 16,
   parameter int FRAC   = 14,
   parameter int MU_W   = 4,
   parameter int RST_RE = 0
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 upd,
   input  logic signed [DW-1:0] x_re,
   input  logic signed [DW-1:0] x_im,
   input  logic signed [DW-1:0] e_re,
   input  logic signed [DW-1:0] e_im,
   input  logic [MU_W-1:0]      mu_shift,
   output logic signed [DW-1:0] w_re,
   output logic signed [DW-1:0] w_im
);
   function automatic logic signed [DW-1:0] sat_d(input logic signed [63:0] v);
      logic signed [63:0] hi = (64'sd1 <<< (DW - 1)) - 64'sd1;
      logic signed [63:0] lo = -(64'sd1 <<< (DW - 1));
      if (v > hi) return hi[DW-1:0];
      if (v < lo) return lo[DW-1:0];
      return v[DW-1:0];
   endfunction

   int sh;
   logic signed [63:0] grad_re, grad_im, step_re, step_im;
   logic signed [DW-1:0] nxt_re, nxt_im;

   assign sh = FRAC + int'(mu_shift);
   // x * conj(e)
   assign grad_re = 64'(x_re) * 64'(e_re) + 64'(x_im) * 64'(e_im);
   assign grad_im = 64'(x_im) * 64'(e_re) - 64'(x_re) * 64'(e_im);
   assign step_re = round_shift(grad_re, sh);
   assign step_im = round_shift(grad_im, sh);
   assign nxt_re  = sat_d(64'(w_re) + step_re);
   assign nxt_im  = sat_d(64'(w_im) + step_im);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_re <= DW'(RST_RE);
         w_im <= '0;
      end else if (upd) begin
         w_re <= nxt_re;
         w_im <= nxt_im;
      end
   end
endmodule

// File: rtl/cmab_beamformer.sv
module cmab_beamformer import cmab_pkg::*; #(
   parameter int NUM_ANT = 4,
   parameter int DW      = 16,
   parameter int FRAC    = 14,
   parameter int MU_W    = 4
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [NUM_ANT*DW-1:0]   x_re,
   input  logic [NUM_ANT*DW-1:0]   x_im,
   input  logic signed [DW-1:0]    ref_re,
   input  logic signed [DW-1:0]    ref_im,
   input  logic                    lms_mode,
   input  logic [MU_W-1:0]         mu_shift,
   output logic                    out_valid,
   output logic signed [DW-1:0]    y_re,
   output logic signed [DW-1:0]    y_im
);
   localparam int VEC_W = NUM_ANT * DW;
   localparam int ONE   = 1 << FRAC;

   if (NUM_ANT < 1) begin : g_bad_ant
      $error("cmab_beamformer: NUM_ANT must be at least 1");
   end
   if (FRAC < 1 || FRAC > DW - 2) begin : g_bad_frac
      $error("cmab_beamformer: FRAC must leave room for 1.0 inside DW");
   end
   if (2 * DW + $clog2(NUM_ANT) + 3 > 64 || FRAC + (1 << MU_W) > 62) begin : g_bad_width
      $error("cmab_beamformer: widths exceed the 64-bit datapath");
   end

   logic [VEC_W-1:0]     w_re_all, w_im_all;
   logic signed [DW-1:0] y_cmb_re, y_cmb_im, err_re, err_im;
   err_sel_e             sel;

   assign sel = err_sel_e'(lms_mode);

   cmab_combiner #(.NUM_ANT(NUM_ANT), .DW(DW), .FRAC(FRAC)) comb_i (
      .x_re(x_re), .x_im(x_im), .w_re(w_re_all), .w_im(w_im_all),
      .y_re(y_cmb_re), .y_im(y_cmb_im)
   );

   cmab_error #(.DW(DW), .FRAC(FRAC)) err_i (
      .sel(sel), .y_re(y_cmb_re), .y_im(y_cmb_im),
      .ref_re(ref_re), .ref_im(ref_im), .e_re(err_re), .e_im(err_im)
   );

   for (genvar k = 0; k < NUM_ANT; k++) begin : g_lane
      cmab_weight_lane #(
         .DW(DW), .FRAC(FRAC), .MU_W(MU_W), .RST_RE((k == 0) ? ONE : 0)
      ) lane_i (
         .clk(clk), .rst_n(rst_n), .upd(in_valid),
         .x_re(x_re[k*DW +: DW]), .x_im(x_im[k*DW +: DW]),
         .e_re(err_re), .e_im(err_im), .mu_shift(mu_shift),
         .w_re(w_re_all[k*DW +: DW]), .w_im(w_im_all[k*DW +: DW])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         y_re      <= '0;
         y_im      <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            y_re <= y_cmb_re;
            y_im <= y_cmb_im;
         end
      end
   end
endmodule

// File: rtl/cmab_checker.sv
module cmab_checker #(
   parameter int NUM_ANT = 4,
   parameter int DW      = 16
)(
   input logic                  clk,
   input logic                  rst_n,
   input logic                  in_valid,
   input logic                  lms_mode,
   input logic signed [DW-1:0]  ref_re,
   input logic signed [DW-1:0]  ref_im,
   input logic signed [DW-1:0]  y_now_re,
   input logic signed [DW-1:0]  y_now_im,
   input logic                  out_valid,
   input logic signed [DW-1:0]  y_re,
   input logic signed [DW-1:0]  y_im,
   input logic [NUM_ANT*DW-1:0] w_re_all,
   input logic [NUM_ANT*DW-1:0] w_im_all
);
   p_valid_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_idle_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_hold_output_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(y_re) && $stable(y_im)));

   p_output_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (y_re == $past(y_now_re) && y_im == $past(y_now_im)));

   p_frozen_weights_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(w_re_all) && $stable(w_im_all)));

   p_zero_error_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && lms_mode && ref_re == y_now_re && ref_im == y_now_im)
      |=> ($stable(w_re_all) && $stable(w_im_all)));
endmodule

bind cmab_beamformer cmab_checker #(.NUM_ANT(NUM_ANT), .DW(DW)) chk_i (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lms_mode(lms_mode),
   .ref_re(ref_re), .ref_im(ref_im), .y_now_re(y_cmb_re), .y_now_im(y_cmb_im),
   .out_valid(out_valid), .y_re(y_re), .y_im(y_im),
   .w_re_all(w_re_all), .w_im_all(w_im_all)
);

// File: tb/cmab_beamformer_tb_top.sv
`timescale 1ns/1ps
module cmab_beamformer_tb_top;
   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic [63:0]        x_re = '0, x_im = '0;
   logic signed [15:0] ref_re = '0, ref_im = '0;
   logic               lms_mode = 1'b0;
   logic [3:0]         mu_shift = '0;
   logic               out_valid;
   logic signed [15:0] y_re, y_im;

   int checks = 0;
   int fails  = 0;

   typedef struct { longint re; longint im; string tag; } exp_t;
   exp_t   q[$];
   longint mw_re[4], mw_im[4];
   longint last_re = 0, last_im = 0;
   longint vr[4], vi[4];

   always #5 clk = ~clk;

   cmab_beamformer dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_re(x_re), .x_im(x_im),
      .ref_re(ref_re), .ref_im(ref_im), .lms_mode(lms_mode), .mu_shift(mu_shift),
      .out_valid(out_valid), .y_re(y_re), .y_im(y_im)
   );

   function automatic longint rsh(longint v, int s);
      return (v + (longint'(1) <<< (s - 1))) >>> s;
   endfunction

   function automatic longint sat16(longint v);
      if (v > 32767) return 32767;
      if (v < -32768) return -32768;
      return v;
   endfunction

   task automatic check(string tag, longint act, longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < 4; k++) begin mw_re[k] = 0; mw_im[k] = 0; end
      mw_re[0] = 16384;
      last_re = 0; last_im = 0;
   endtask

   task automatic send(longint xr[4], longint xi[4], longint rr, longint ri,
                       bit mode, int sh, string tag);
      longint ar = 0, ai = 0, yr, yi, er, ei, m, g;
      exp_t e;
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
         x_re[k*16 +: 16] = 16'(xr[k]);
         x_im[k*16 +: 16] = 16'(xi[k]);
      end
      ref_re = 16'(rr); ref_im = 16'(ri);
      lms_mode = mode; mu_shift = 4'(sh); in_valid = 1'b1;
      for (int k = 0; k < 4; k++) begin
         ar += mw_re[k] * xr[k] + mw_im[k] * xi[k];
         ai += mw_re[k] * xi[k] - mw_im[k] * xr[k];
      end
      yr = sat16(rsh(ar, 14)); yi = sat16(rsh(ai, 14));
      e.re = yr; e.im = yi; e.tag = tag;
      q.push_back(e);
      if (mode) begin
         er = sat16(rr - yr); ei = sat16(ri - yi);
      end else begin
         m = rsh(yr * yr + yi * yi, 14);
         g = 16384 - m;
         er = sat16(rsh(g * yr, 14)); ei = sat16(rsh(g * yi, 14));
      end
      for (int k = 0; k < 4; k++) begin
         mw_re[k] = sat16(mw_re[k] + rsh(xr[k] * er + xi[k] * ei, 14 + sh));
         mw_im[k] = sat16(mw_im[k] + rsh(xi[k] * er - xr[k] * ei, 14 + sh));
      end
   endtask

   task automatic go_idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic rand_vec(int amp);
      for (int k = 0; k < 4; k++) begin
         vr[k] = longint'($urandom_range(2 * amp)) - amp;
         vi[k] = longint'($urandom_range(2 * amp)) - amp;
      end
   endtask

   // scoreboard monitor
   always @(posedge clk) begin
      #1;
      if (rst_n && out_valid) begin
         if (q.size() == 0) begin
            checks++; fails++;
            $display("FAIL R3: unexpected out_valid, actual 1 expected 0");
         end else begin
            exp_t e;
            e = q.pop_front();
            check({e.tag, " y_re"}, longint'(y_re), e.re);
            check({e.tag, " y_im"}, longint'(y_im), e.im);
            last_re = e.re; last_im = e.im;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      do_reset();
      // R1 reset state
      check("R1 out_valid", longint'(out_valid), 0);
      check("R1 y_re", longint'(y_re), 0);
      check("R1 y_im", longint'(y_im), 0);

      // R1 first output equals antenna 0
      vr = '{5000, -3000, 7000, 1200}; vi = '{-2500, 900, -4000, 333};
      send(vr, vi, 5000, -2500, 1'b1, 3, "R1 first");
      check("R1 model first equals x0", q[0].re, 5000);

      // R5 reference-driven adaptation
      for (int n = 0; n < 40; n++) begin
         rand_vec(4096);
         send(vr, vi, 3000, -1000, 1'b1, 2, "R5 ref error");
      end

      // R3 idle: valid drops, output held; R4 inputs wiggled while idle
      go_idle();
      @(negedge clk);
      check("R3 out_valid low", longint'(out_valid), 0);
      check("R3 y_re held", longint'(y_re), last_re);
      check("R3 y_im held", longint'(y_im), last_im);
      for (int n = 0; n < 5; n++) begin
         @(negedge clk);
         x_re = {$urandom, $urandom}; x_im = {$urandom, $urandom};
         ref_re = 16'($urandom); ref_im = 16'($urandom);
         lms_mode = n[0]; mu_shift = 4'd0;
      end
      rand_vec(4096);
      send(vr, vi, 0, 0, 1'b1, 2, "R4 weights frozen");
      send(vr, vi, 0, 0, 1'b1, 2, "R2 repeat after update");

      // R6 blind modulus mode from fresh weights
      do_reset();
      for (int n = 0; n < 40; n++) begin
         rand_vec(9000);
         send(vr, vi, 0, 0, 1'b0, 4, "R6 modulus error");
      end
      for (int n = 0; n < 10; n++) begin
         rand_vec(20000);
         send(vr, vi, -7000, 7000, 1'b0, 1, "R2 mixed pattern");
      end

      // R7 step size extremes
      do_reset();
      for (int n = 0; n < 8; n++) begin
         vr = '{6000, -6000, 2000, 100}; vi = '{1000, 3000, -5000, 0};
         send(vr, vi, 12000, 4000, 1'b1, 15, "R7 shift 15");
      end
      for (int n = 0; n < 8; n++) begin
         vr = '{6000, -6000, 2000, 100}; vi = '{1000, 3000, -5000, 0};
         send(vr, vi, 12000, 4000, 1'b1, 0, "R7 shift 0");
      end

      // R8 weight clamp, R9 output clamp
      do_reset();
      vr = '{32767, 32767, 32767, 32767}; vi = '{0, 0, 0, 0};
      send(vr, vi, -32768, 0, 1'b1, 0, "R8 weight clamp");
      send(vr, vi, -32768, 0, 1'b1, 0, "R9 output clamp");
      send(vr, vi, 32767, 32767, 1'b1, 0, "R8 clamp after swing");
      send(vr, vi, 32767, 32767, 1'b1, 0, "R9 output clamp high");
      go_idle();
      repeat (3) @(negedge clk);
      check("R3 queue drained", longint'(q.size()), 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule